// File: doc/BRIEF.md
# SPI Slave Port

This block is a serial peripheral interface slave that moves one byte in each direction per transfer while the select line is held low. The external master chooses one of four clock formats. The polarity bit sets the level the serial clock rests at. The phase bit sets whether incoming data is captured on the first or the second clock edge of each bit. Data travels most significant bit first. The serial inputs are brought into the system clock domain through two-flop synchronizers, and clock edges are found by comparing successive synchronized samples. The system clock must therefore run at least four times faster than the serial clock.

Software talks to the block through a small register bus. That bus holds the transmit byte, a control word and a status word. Transmit data is single-buffered: the written byte waits in a holding register and is copied into the shifter only when a byte begins. Receive data is double-buffered: a finished byte is copied out of the shifter into a read register, so the shifter can take the next byte at once. Three sticky status flags report a finished byte, a write collision and a receive overrun.

Top module: `spi_slave_port`

## Requirements
- R1: After reset the control word (address 1) and the status word (address 2) read as zero, and the data-output enable is low.
- R2: In all four clock formats the master receives the byte last written to the data register (address 0), and the slave captures the master's byte, both most significant bit first. Control bit 0 enables the port, bit 1 is the clock polarity and bit 2 is the clock phase.
- R3: With phase 0, once a byte has completed, further clock edges are ignored until select has gone high and then low again. Only then is the next byte received.
- R4: With phase 1, select may stay low across consecutive bytes. A data write made between two bytes is sent in the next byte.
- R5: A data-register write while select is low (phase 0), or partway through a byte (phase 1), sets the collision flag (status bit 1). The write is discarded, and the byte on the wire is unchanged.
- R6: A completed byte is placed in the read register and sets the complete flag (status bit 0).
- R7: When a byte completes while the complete flag is still set, the overrun flag (status bit 2) is set. The read register keeps the older byte.
- R8: Reading the data register clears the complete and overrun flags. Writing 1 to a status bit clears that bit.
- R9: A write to the polarity bit takes effect only while the port is disabled. A write made while enabled leaves the polarity unchanged.
- R10: The data-output enable is high only while the port is enabled and select is low.
- R11: While the port is disabled, serial activity completes no byte and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for the selected address |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o |

## Verification
A bit counter that is off by one shows up within the same byte. Both serial bytes come out rotated, and the complete flag rises one edge early or late. A phase-0 hold state that is not set shows up on the next set of clock edges, because the status word reports an extra completed byte. A transmit holding register that takes a colliding write shows up one byte later, when the master receives the discarded value instead of the old one. The overrun and read-register paths show up at the first data read after two unread bytes.

// File: rtl/spis_pkg.sv
// Shared constants for the SPI slave port: register addresses and bit positions.
package spis_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_STAT = 2'd2
    } reg_addr_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_CPOL = 1;
    localparam int CTL_CPHA = 2;

    localparam int ST_DONE = 0;
    localparam int ST_WCOL = 1;
    localparam int ST_OVF  = 2;
endpackage

// File: rtl/spis_sync.sv
// Multi-stage synchronizer for asynchronous inputs.
// Assumes each input bit is independent, or is allowed one cycle of skew.
module spis_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
// Edge detector on the synchronized serial clock and select.
// The leading and trailing edges are mapped through the clock polarity.
// Assumes the serial clock rests at the polarity level between bytes.
module spis_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic ss_n_s,
    input  logic cpol,
    output logic lead,
    output logic trail,
    output logic ss_fall
);
    logic sck_q;
    logic ss_q;
    logic rise;
    logic fall;

    // Keep the previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            ss_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            ss_q  <= ss_n_s;
        end
    end

    // Classify edges as leading or trailing for the selected polarity.
    always_comb begin
        rise    = sck_s & ~sck_q;
        fall    = ~sck_s & sck_q;
        lead    = cpol ? fall : rise;
        trail   = cpol ? rise : fall;
        ss_fall = ss_q & ~ss_n_s;
    end
endmodule

// File: rtl/spis_shifter.sv
// Serial shift engine: bit counter, transmit shifter and receive shifter.
// With phase 0 it samples on leading edges, shifts on trailing edges, and
// holds after each byte until select is released.
// With phase 1 it loads or shifts on leading edges and samples on trailing edges.
// Assumes DATA_W >= 2.
module spis_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpha,
    input  logic              lead,
    input  logic              trail,
    input  logic              ss_fall,
    input  logic              ss_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic              done_pulse,
    output logic [DATA_W-1:0] rx_byte,
    output logic              mid_frame
);
    localparam int              CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic              hold;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-2:0] rx_sh;
    logic              sample_edge;
    logic              shift_edge;
    logic              active;

    // Choose which edge samples and which edge shifts, and gate on activity.
    always_comb begin
        sample_edge = cpha ? trail : lead;
        shift_edge  = cpha ? lead : trail;
        active      = en & ~ss_n_s & ~ss_fall & ~hold;
    end

    // Bit counter and the phase-0 end-of-byte hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hold <= 1'b0;
        end else if (!en || ss_n_s || ss_fall) begin
            cnt  <= '0;
            hold <= 1'b0;
        end else if (active && sample_edge) begin
            if (cnt == LAST) begin
                cnt  <= '0;
                hold <= ~cpha;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Transmit shifter: load at byte start, then move one bit per shift edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (en && ss_fall) begin
            tx_sh <= tx_data;
        end else if (active && shift_edge) begin
            if (cpha && cnt == '0) tx_sh <= tx_data;
            else                   tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    // Receive shifter: capture one bit per sample edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (active && sample_edge) begin
            if (DATA_W > 2) rx_sh <= {rx_sh[DATA_W-3:0], mosi_s};
            else            rx_sh <= mosi_s;
        end
    end

    // Outputs: current transmit bit, byte completion and the collision window.
    always_comb begin
        miso       = tx_sh[DATA_W-1];
        done_pulse = active & sample_edge & (cnt == LAST);
        rx_byte    = {rx_sh, mosi_s};
        mid_frame  = en & ~ss_n_s & (~cpha | (cnt != '0));
    end
endmodule

// File: rtl/spis_regs.sv
// Register file: control word, transmit holding register, receive read register
// and the sticky status flags.
// Hardware set wins over a software clear in the same cycle.
// Assumes DATA_W >= 3, so the control and status bits fit.
module spis_regs import spis_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              done_pulse,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              mid_frame,
    output logic              en_o,
    output logic              cpol_o,
    output logic              cpha_o,
    output logic [DATA_W-1:0] tx_buf_o,
    output logic [DATA_W-1:0] rd_buf_o,
    output logic              st_done_o,
    output logic              st_wcol_o,
    output logic              st_ovf_o
);
    logic wr_data;
    logic wr_ctrl;
    logic wr_stat;
    logic rd_data;

    // Decode the register strobes.
    always_comb begin
        wr_data = reg_wr && (reg_addr == REG_DATA);
        wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
        wr_stat = reg_wr && (reg_addr == REG_STAT);
        rd_data = reg_rd && (reg_addr == REG_DATA);
    end

    // Control word; polarity is locked while the port is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            cpol_o <= 1'b0;
            cpha_o <= 1'b0;
        end else if (wr_ctrl) begin
            en_o   <= reg_wdata[CTL_EN];
            cpha_o <= reg_wdata[CTL_CPHA];
            if (!en_o) cpol_o <= reg_wdata[CTL_CPOL];
        end
    end

    // Transmit holding register; a write inside a frame is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf_o <= '0;
        end else if (wr_data && !mid_frame) begin
            tx_buf_o <= reg_wdata;
        end
    end

    // Receive read register; it takes a new byte only when it is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf_o <= '0;
        end else if (done_pulse && !st_done_o) begin
            rd_buf_o <= rx_byte;
        end
    end

    // Sticky flags: software clears first, hardware sets last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done_o <= 1'b0;
            st_wcol_o <= 1'b0;
            st_ovf_o  <= 1'b0;
        end else begin
            if (wr_stat) begin
                if (reg_wdata[ST_DONE]) st_done_o <= 1'b0;
                if (reg_wdata[ST_WCOL]) st_wcol_o <= 1'b0;
                if (reg_wdata[ST_OVF])  st_ovf_o  <= 1'b0;
            end
            if (rd_data) begin
                st_done_o <= 1'b0;
                st_ovf_o  <= 1'b0;
            end
            if (wr_data && mid_frame) st_wcol_o <= 1'b1;
            if (done_pulse) begin
                if (st_done_o) st_ovf_o  <= 1'b1;
                else           st_done_o <= 1'b1;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_DATA: reg_rdata = rd_buf_o;
            REG_CTRL: begin
                reg_rdata[CTL_EN]   = en_o;
                reg_rdata[CTL_CPOL] = cpol_o;
                reg_rdata[CTL_CPHA] = cpha_o;
            end
            REG_STAT: begin
                reg_rdata[ST_DONE] = st_done_o;
                reg_rdata[ST_WCOL] = st_wcol_o;
                reg_rdata[ST_OVF]  = st_ovf_o;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_slave_port.sv
// SPI slave port top: synchronizers, edge detector, shift engine and register file.
// Assumes the system clock runs at least four times faster than the serial clock.
module spi_slave_port import spis_pkg::*; #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o
);
    logic              sck_s, ss_n_s, mosi_s;
    logic              lead, trail, ss_fall;
    logic              en_q, cpol_q, cpha_q;
    logic [DATA_W-1:0] tx_buf, rd_buf, rx_byte;
    logic              done_pulse, mid_frame;
    logic              st_done, st_wcol, st_ovf;

    spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, ss_n_i, mosi_i}),
        .q     ({sck_s, ss_n_s, mosi_s})
    );

    spis_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .ss_n_s  (ss_n_s),
        .cpol    (cpol_q),
        .lead    (lead),
        .trail   (trail),
        .ss_fall (ss_fall)
    );

    spis_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .cpha       (cpha_q),
        .lead       (lead),
        .trail      (trail),
        .ss_fall    (ss_fall),
        .ss_n_s     (ss_n_s),
        .mosi_s     (mosi_s),
        .tx_data    (tx_buf),
        .miso       (miso_o),
        .done_pulse (done_pulse),
        .rx_byte    (rx_byte),
        .mid_frame  (mid_frame)
    );

    spis_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .done_pulse (done_pulse),
        .rx_byte    (rx_byte),
        .mid_frame  (mid_frame),
        .en_o       (en_q),
        .cpol_o     (cpol_q),
        .cpha_o     (cpha_q),
        .tx_buf_o   (tx_buf),
        .rd_buf_o   (rd_buf),
        .st_done_o  (st_done),
        .st_wcol_o  (st_wcol),
        .st_ovf_o   (st_ovf)
    );

    // Drive the data line only while this slave is enabled and selected.
    always_comb miso_oe_o = en_q & ~ss_n_s;
endmodule

// File: rtl/spis_checker.sv
// Property checker for the SPI slave port, attached to the top by bind.
module spis_checker import spis_pkg::*; #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              en_q,
    input logic              cpol_q,
    input logic              done_pulse,
    input logic              mid_frame,
    input logic              st_done,
    input logic              st_wcol,
    input logic              st_ovf,
    input logic [DATA_W-1:0] tx_buf,
    input logic [DATA_W-1:0] rd_buf
);
    AST_CPOL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> $stable(cpol_q)); // R9

    AST_DONE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> $past(done_pulse)); // R6

    AST_OVF_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && st_done) |=> (st_ovf && $stable(rd_buf))); // R7

    AST_WCOL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_DATA && mid_frame) |=> (st_wcol && $stable(tx_buf))); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == REG_DATA && !done_pulse) |=> (!st_done && !st_ovf)); // R8
endmodule

bind spi_slave_port spis_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .en_q       (en_q),
    .cpol_q     (cpol_q),
    .done_pulse (done_pulse),
    .mid_frame  (mid_frame),
    .st_done    (st_done),
    .st_wcol    (st_wcol),
    .st_ovf     (st_ovf),
    .tx_buf     (tx_buf),
    .rd_buf     (rd_buf)
);

// File: tb/sim_spi_slave_port.sv
module sim_spi_slave_port;
    localparam int HALF = 8;
    localparam int NV   = 8;
    // Each entry: {cpol, cpha, master byte, slave byte}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'hA5, 8'h3C}, {1'b0, 1'b1, 8'h5A, 8'hC3},
        {1'b1, 1'b0, 8'h81, 8'h7E}, {1'b1, 1'b1, 8'hFF, 8'h00},
        {1'b0, 1'b0, 8'h01, 8'h80}, {1'b1, 1'b1, 8'h96, 8'h69},
        {1'b0, 1'b1, 8'h00, 8'hFF}, {1'b1, 1'b0, 8'h7F, 8'hFE}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso_o, miso_oe_o;
    logic       cpol_b = 1'b0, cpha_b = 1'b0;
    int         n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    spi_slave_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ss_on();
        @(negedge clk); ss_n = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic ss_off();
        @(negedge clk); ss_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    // Bit-level master: drive and sample as the selected clock format dictates.
    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            if (!cpha_b) begin
                mosi = tx[i];
                repeat (HALF) @(negedge clk);
                rx[i] = miso_o; sck = ~cpol_b;
                repeat (HALF) @(negedge clk);
                sck = cpol_b;
            end else begin
                repeat (HALF) @(negedge clk);
                sck = ~cpol_b; mosi = tx[i];
                repeat (HALF) @(negedge clk);
                rx[i] = miso_o; sck = cpol_b;
            end
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic set_mode(input logic pol, input logic pha, input logic en);
        reg_write(2'd1, {5'b0, pha, pol, 1'b0});
        @(negedge clk); sck = pol; cpol_b = pol; cpha_b = pha;
        repeat (4) @(negedge clk);
        if (en) reg_write(2'd1, {5'b0, pha, pol, 1'b1});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d, rx;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        reg_read(2'd1, d); chk("R1 ctrl", d, 8'h00);
        reg_read(2'd2, d); chk("R1 status", d, 8'h00);
        chk("R1 oe", miso_oe_o, 1'b0);

        // Vector table: the four formats in both directions (R2, R6, R8, R10)
        for (int k = 0; k < NV; k++) begin
            logic [17:0] v;
            v = VEC[k];
            set_mode(v[17], v[16], 1'b1);
            reg_write(2'd0, v[7:0]);
            ss_on();
            chk("R10 oe selected", miso_oe_o, 1'b1);
            spi_byte(v[15:8], rx);
            ss_off();
            chk("R10 oe released", miso_oe_o, 1'b0);
            chk("R2 master rx", rx, v[7:0]);
            reg_read(2'd2, d); chk("R6 done set", d, 8'h01);
            reg_read(2'd0, d); chk("R2 slave rx", d, v[15:8]);
            reg_read(2'd2, d); chk("R8 read clears", d, 8'h00);
        end

        // R3: phase 0 needs select toggled between bytes
        set_mode(1'b0, 1'b0, 1'b1);
        ss_on();
        spi_byte(8'hC4, rx);
        reg_read(2'd0, d); chk("R3 first byte", d, 8'hC4);
        spi_byte(8'h3B, rx);
        reg_read(2'd2, d); chk("R3 held without reselect", d, 8'h00);
        ss_off(); ss_on();
        spi_byte(8'h3B, rx);
        ss_off();
        reg_read(2'd0, d); chk("R3 after reselect", d, 8'h3B);

        // R5: phase 0 write while selected
        reg_write(2'd0, 8'h11);
        ss_on();
        reg_write(2'd0, 8'hEE);
        spi_byte(8'h55, rx);
        ss_off();
        chk("R5 byte intact ph0", rx, 8'h11);
        reg_read(2'd2, d); chk("R5 wcol ph0", d, 8'h03);
        reg_read(2'd0, d);
        reg_write(2'd2, 8'h02);
        reg_read(2'd2, d); chk("R8 w1c wcol", d, 8'h00);
        ss_on(); spi_byte(8'h66, rx); ss_off();
        chk("R5 write dropped ph0", rx, 8'h11);
        reg_write(2'd2, 8'h01);
        reg_read(2'd2, d); chk("R8 w1c done", d, 8'h00);

        // R4 and R5: phase 1, back to back with select low
        set_mode(1'b0, 1'b1, 1'b1);
        reg_write(2'd0, 8'h5C);
        ss_on();
        spi_byte(8'h10, rx);
        chk("R4 first byte out", rx, 8'h5C);
        reg_read(2'd0, d); chk("R4 first byte in", d, 8'h10);
        reg_write(2'd0, 8'hA3);
        reg_read(2'd2, d); chk("R4 no wcol between bytes", d, 8'h00);
        fork
            spi_byte(8'h20, rx);
            begin
                repeat (HALF * 5) @(negedge clk);
                reg_write(2'd0, 8'h77);
            end
        join
        chk("R4 second byte out", rx, 8'hA3);
        reg_read(2'd2, d); chk("R5 wcol ph1", d, 8'h03);
        reg_read(2'd0, d); chk("R4 second byte in", d, 8'h20);
        spi_byte(8'h30, rx);
        ss_off();
        chk("R5 write dropped ph1", rx, 8'hA3);
        reg_read(2'd0, d); chk("R4 third byte in", d, 8'h30);
        reg_write(2'd2, 8'h02);

        // R7 overrun keeps the older byte
        set_mode(1'b0, 1'b0, 1'b1);
        ss_on(); spi_byte(8'h12, rx); ss_off();
        ss_on(); spi_byte(8'h34, rx); ss_off();
        reg_read(2'd2, d); chk("R7 ovf set", d, 8'h05);
        reg_read(2'd0, d); chk("R7 old byte kept", d, 8'h12);
        reg_read(2'd2, d); chk("R8 read clears ovf", d, 8'h00);

        // R9 polarity lock
        reg_write(2'd1, 8'h03);
        reg_read(2'd1, d); chk("R9 locked", d, 8'h01);
        reg_write(2'd1, 8'h00);
        reg_write(2'd1, 8'h02);
        reg_read(2'd1, d); chk("R9 change disabled", d, 8'h02);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, d); chk("R9 cleared disabled", d, 8'h00);

        // R11 disabled port ignores traffic
        set_mode(1'b0, 1'b0, 1'b0);
        ss_on();
        chk("R11 oe disabled", miso_oe_o, 1'b0);
        spi_byte(8'h9E, rx);
        ss_off();
        reg_read(2'd2, d); chk("R11 no flags", d, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule